// File: doc/BRIEF.md
# Indexed IDE Host Configuration Register File

This block holds the byte-wide configuration state of a dual-channel IDE host controller. The host reaches it through two I/O addresses. It first writes a register number to the index port. It then reads or writes the chosen byte at the data port, four addresses above. The index stays latched, so any number of data-port accesses reach the same register until the index is written again.

A strap input picks which of two base addresses the ports answer at. The block keeps the command-block timing, the per-drive address-setup and read/write timings, the prefetch burst size, a control byte and a scratch byte. It also returns a read-only identity byte that reports the revision and the strap. The decoded fields go straight to the timing and prefetch logic: one prefetch-disable flag per drive, the secondary-channel enable and the fast host-timing select. The four prefetch-disable flags live in two different registers.

Top module: `ide_cfg_regfile`

## Requirements
- R1: After reset, register 0x51 reads 0xC0 and register 0x57 reads 0x0C. Registers 0x52–0x56, 0x58, 0x59 and 0x5B read 0x00. `pf_dis` is 4'hF, and `sec_en` and `fast_host` are 0.
- R2: With `alt_base`=0 the index port is at 0x178 and the data port at 0x17C. With `alt_base`=1 they are at 0x078 and 0x07C. A write to any other address changes no state. A read of any other address returns 0xFF. A read of the index port returns the latched index.
- R3: A byte written at the data port to index 0x51–0x59 or 0x5B reads back unchanged at the data port. The update is visible from the clock edge that takes the write.
- R4: Index 0x50 is read-only. It reads bits 1:0 = the `DEV_REV` parameter (nonzero), bit 5 = `alt_base`, and all other bits 0. Writes to it have no effect.
- R5: Every index outside 0x50–0x59 and 0x5B, including 0x5A, reads 0xFF. Writes to these indices change no register.
- R6: `pf_dis[0]` is bit 6 of 0x51, `pf_dis[1]` is bit 7 of 0x51, `pf_dis[2]` is bit 2 of 0x57, and `pf_dis[3]` is bit 3 of 0x57.
- R7: `sec_en` equals bit 3 of register 0x51.
- R8: `fast_host` is 1 exactly when bits 0, 1, 2 and 5 of register 0x51 are all set (mask 0x27).
- R9: `cmd_timing` mirrors 0x52 and `burst_size` mirrors 0x59. `setup_tim[0]`, `setup_tim[1]` and `setup_tim[2]` mirror 0x53, 0x55 and 0x57. `rw_tim[0]`, `rw_tim[1]` and `rw_tim[2]` mirror 0x54, 0x56 and 0x58.
- R10: The latched index holds the full written byte. It is unchanged by data-port accesses, so repeated data accesses reach the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alt_base | input | 1 | Base address strap: 1 selects 0x078, 0 selects 0x178 |
| io_addr | input | 10 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte for the addressed port |
| pf_dis | output | 4 | Prefetch disable, one bit per drive |
| sec_en | output | 1 | Secondary channel enable |
| fast_host | output | 1 | Fast host timing select |
| cmd_timing | output | 8 | Command-block timing byte |
| setup_tim | output | 3x8 | Address-setup bytes: drive 0, drive 1, drives 2/3 |
| rw_tim | output | 3x8 | Read/write timing bytes: drive 0, drive 1, drives 2/3 |
| burst_size | output | 8 | Prefetch burst-size byte |

## Verification
Two kinds of write change several exported functions in the same clock edge.

A single write to 0x51 moves the drive 0/1 prefetch flags, the secondary enable and the fast-timing select together. A single write to 0x57 moves the drive 2/3 setup byte and the drive 2/3 prefetch flags together.

The bench sweeps all 256 values through each of these two registers. After every write it compares all affected outputs against values derived arithmetically from the written byte. This confirms that no field lags or leaks into a neighbour.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int IDX_W = 8;
  localparam logic [7:0] IDX_IDENT  = 8'h50;
  localparam logic [7:0] IDX_FIRST  = 8'h51;
  localparam int NUM_SLOTS = 11;          // 0x51 .. 0x5B
  localparam int SLOT_CTRL  = 0;          // 0x51
  localparam int SLOT_CMDT  = 1;          // 0x52
  localparam int SLOT_TIM0  = 2;          // 0x53 first per-drive pair
  localparam int SLOT_S23   = 6;          // 0x57
  localparam int SLOT_BURST = 8;          // 0x59
  localparam int SLOT_HOLE  = 9;          // 0x5A unimplemented
  localparam int CTRL_PF0 = 6;
  localparam int CTRL_PF1 = 7;
  localparam int CTRL_SEC = 3;
  localparam int S23_PF2  = 2;
  localparam int S23_PF3  = 3;
  localparam logic [7:0] FAST_MASK = 8'h27;

  function automatic logic slot_is_rw(int s);
    return s != SLOT_HOLE;
  endfunction

  function automatic logic [7:0] slot_reset(int s);
    if (s == SLOT_CTRL) return 8'hC0;
    if (s == SLOT_S23)  return 8'h0C;
    return 8'h00;
  endfunction

  function automatic logic [7:0] ident_byte(logic [1:0] rev, logic alt);
    return {2'b00, alt, 3'b000, rev};
  endfunction

  function automatic logic fast_of(logic [7:0] ctrl);
    return (ctrl & FAST_MASK) == FAST_MASK;
  endfunction

  function automatic logic idx_implemented(logic [7:0] idx);
    return (idx >= IDX_FIRST && idx <= 8'h59) || idx == 8'h5B;
  endfunction
endpackage

// File: rtl/ide_cfg_port_decode.sv
module ide_cfg_port_decode #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] PRI_BASE = 10'h178,
  parameter logic [ADDR_W-1:0] ALT_BASE = 10'h078,
  parameter logic [ADDR_W-1:0] DATA_OFS = 10'd4
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              alt_base,
  output logic              idx_hit,
  output logic              dat_hit,
  output logic              idx_wr,
  output logic              dat_wr
);
  logic [ADDR_W-1:0] base;
  assign base    = alt_base ? ALT_BASE : PRI_BASE;
  assign idx_hit = (io_addr == base);
  assign dat_hit = (io_addr == base + DATA_OFS);
  assign idx_wr  = io_wr & idx_hit;
  assign dat_wr  = io_wr & dat_hit;
endmodule

// File: rtl/ide_cfg_regbank.sv
module ide_cfg_regbank
  import ide_cfg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dat_wr,
  input  logic [IDX_W-1:0]             cur_idx,
  input  logic [7:0]                   wdata,
  output logic [NUM_SLOTS-1:0][7:0]    slot_q
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (slot_is_rw(s)) begin : g_rw
      logic [7:0] q;
      logic       sel;
      assign sel = dat_wr && (cur_idx == IDX_W'(int'(IDX_FIRST) + s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= slot_reset(s);
        else if (sel) q <= wdata;
      end
      assign slot_q[s] = q;
    end else begin : g_hole
      assign slot_q[s] = 8'hFF;
    end
  end
endmodule

// File: rtl/ide_cfg_field_export.sv
module ide_cfg_field_export
  import ide_cfg_pkg::*;
#(
  parameter logic [1:0] DEV_REV = 2'd2
) (
  input  logic [NUM_SLOTS-1:0][7:0] slot_q,
  input  logic [IDX_W-1:0]          cur_idx,
  input  logic                      alt_base,
  output logic [7:0]                rd_byte,
  output logic [3:0]                pf_dis,
  output logic                      sec_en,
  output logic                      fast_host,
  output logic [7:0]                cmd_timing,
  output logic [2:0][7:0]           setup_tim,
  output logic [2:0][7:0]           rw_tim,
  output logic [7:0]                burst_size
);
  always_comb begin
    rd_byte = 8'hFF;
    if (cur_idx == IDX_IDENT) rd_byte = ident_byte(DEV_REV, alt_base);
    for (int s = 0; s < NUM_SLOTS; s++)
      if (cur_idx == IDX_W'(int'(IDX_FIRST) + s)) rd_byte = slot_q[s];
  end

  assign pf_dis = {slot_q[SLOT_S23][S23_PF3], slot_q[SLOT_S23][S23_PF2],
                   slot_q[SLOT_CTRL][CTRL_PF1], slot_q[SLOT_CTRL][CTRL_PF0]};
  assign sec_en     = slot_q[SLOT_CTRL][CTRL_SEC];
  assign fast_host  = fast_of(slot_q[SLOT_CTRL]);
  assign cmd_timing = slot_q[SLOT_CMDT];
  assign burst_size = slot_q[SLOT_BURST];

  for (genvar d = 0; d < 3; d++) begin : g_drv
    assign setup_tim[d] = slot_q[SLOT_TIM0 + 2*d];
    assign rw_tim[d]    = slot_q[SLOT_TIM0 + 2*d + 1];
  end
endmodule

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile
  import ide_cfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [1:0] DEV_REV = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [3:0]        pf_dis,
  output logic              sec_en,
  output logic              fast_host,
  output logic [7:0]        cmd_timing,
  output logic [2:0][7:0]   setup_tim,
  output logic [2:0][7:0]   rw_tim,
  output logic [7:0]        burst_size
);
  logic idx_hit, dat_hit, idx_wr, dat_wr;
  logic [IDX_W-1:0] cur_idx;
  logic [NUM_SLOTS-1:0][7:0] slot_q;
  logic [7:0] rd_byte;

  ide_cfg_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .alt_base(alt_base),
    .idx_hit(idx_hit), .dat_hit(dat_hit), .idx_wr(idx_wr), .dat_wr(dat_wr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_idx <= '0;
    else if (idx_wr) cur_idx <= io_wdata;
  end

  ide_cfg_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .cur_idx(cur_idx),
    .wdata(io_wdata), .slot_q(slot_q));

  ide_cfg_field_export #(.DEV_REV(DEV_REV)) u_exp (
    .slot_q(slot_q), .cur_idx(cur_idx), .alt_base(alt_base), .rd_byte(rd_byte),
    .pf_dis(pf_dis), .sec_en(sec_en), .fast_host(fast_host),
    .cmd_timing(cmd_timing), .setup_tim(setup_tim), .rw_tim(rw_tim),
    .burst_size(burst_size));

  assign io_rdata = dat_hit ? rd_byte : (idx_hit ? cur_idx : 8'hFF);
endmodule

// File: rtl/ide_cfg_regfile_chk.sv
module ide_cfg_regfile_chk
  import ide_cfg_pkg::*;
#(
  parameter logic [1:0] DEV_REV = 2'd2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alt_base,
  input logic             io_wr,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic             idx_hit,
  input logic             dat_hit,
  input logic             idx_wr,
  input logic             dat_wr,
  input logic [7:0]       cur_idx,
  input logic [3:0]       pf_dis,
  input logic             sec_en,
  input logic             fast_host,
  input logic [7:0]       cmd_timing,
  input logic [2:0][7:0]  setup_tim,
  input logic [2:0][7:0]  rw_tim,
  input logic [7:0]       burst_size
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (pf_dis == 4'hF && !sec_en && !fast_host && cmd_timing == 8'h00));

  // R2
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !idx_hit && !dat_hit) |=> ($stable(cur_idx) && $stable(pf_dis) && $stable(burst_size)));

  // R4
  ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_hit && cur_idx == IDX_IDENT) |-> io_rdata == {2'b00, alt_base, 3'b000, DEV_REV});

  // R5
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_implemented(cur_idx)) |=>
      ($stable(pf_dis) && $stable(cmd_timing) && $stable(setup_tim) && $stable(rw_tim) && $stable(burst_size)));

  // R6
  pf_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 8'h51) |=> pf_dis[1:0] == $past(io_wdata[7:6]));

  // R6
  pf_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 8'h57) |=> pf_dis[3:2] == $past(io_wdata[3:2]));

  // R7
  sec_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 8'h51) |=> sec_en == $past(io_wdata[3]));

  // R8
  fast_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cur_idx == 8'h51) |=> fast_host == ($past(io_wdata[0]) && $past(io_wdata[1])
                                                   && $past(io_wdata[2]) && $past(io_wdata[5])));

  // R10
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> cur_idx == $past(io_wdata));

  // R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(cur_idx));
endmodule

bind ide_cfg_regfile ide_cfg_regfile_chk #(.DEV_REV(DEV_REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .alt_base(alt_base), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .idx_hit(idx_hit), .dat_hit(dat_hit), .idx_wr(idx_wr),
  .dat_wr(dat_wr), .cur_idx(cur_idx), .pf_dis(pf_dis), .sec_en(sec_en),
  .fast_host(fast_host), .cmd_timing(cmd_timing), .setup_tim(setup_tim),
  .rw_tim(rw_tim), .burst_size(burst_size));

// File: tb/ide_cfg_regfile_test.sv
module ide_cfg_regfile_test;
  localparam logic [1:0] REV = 2'd2;
  logic clk = 0, rst_n = 0, alt_base = 0, io_wr = 0;
  logic [9:0] io_addr = 10'h000;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata, cmd_timing, burst_size;
  logic [3:0] pf_dis;
  logic sec_en, fast_host;
  logic [2:0][7:0] setup_tim, rw_tim;
  int n_chk = 0, n_fail = 0;
  logic [7:0] model [256];
  logic [9:0] base;

  always #2 clk = ~clk;

  ide_cfg_regfile #(.DEV_REV(REV)) uut (.*);

  assign base = alt_base ? 10'h078 : 10'h178;

  function automatic bit impl(int i);
    return (i >= 'h51 && i <= 'h59) || i == 'h5B;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [9:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic reg_write(int idx, logic [7:0] d);
    io_write(base, 8'(idx));
    io_write(base + 10'd4, d);
  endtask

  task automatic reg_read_chk(int idx, string req);
    io_write(base, 8'(idx));
    io_addr = base + 10'd4; #1;
    chk(req, io_rdata, model[idx]);
  endtask

  task automatic read_all();
    for (int i = 0; i < 256; i++)
      reg_read_chk(i, i == 'h50 ? "R4" : (impl(i) ? "R3" : "R5"));
  endtask

  task automatic outputs_chk();
    chk("R9", cmd_timing, model['h52]);
    chk("R9", burst_size, model['h59]);
    for (int d = 0; d < 3; d++) begin
      chk("R9", setup_tim[d], model['h53 + 2*d]);
      chk("R9", rw_tim[d], model['h54 + 2*d]);
    end
  endtask

  task automatic model_ident();
    model['h50] = {2'b00, alt_base, 3'b000, REV};
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = impl(i) ? 8'h00 : 8'hFF;
    model['h51] = 8'hC0; model['h57] = 8'h0C; model_ident();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1", {4'b0, pf_dis}, 8'h0F);
    chk("R1", {7'b0, sec_en}, 8'h00);
    chk("R1", {7'b0, fast_host}, 8'h00);
    outputs_chk();
    read_all();
    // R3 round trip on every writable index
    for (int i = 'h51; i <= 'h5B; i++) if (impl(i)) begin
      model[i] = 8'(i * 29 + 7);
      reg_write(i, model[i]);
    end
    read_all();
    outputs_chk();
    // R5 / R4 writes to holes and the identity byte are ignored
    for (int i = 0; i < 256; i++) if (!impl(i)) reg_write(i, 8'h5A);
    read_all();
    outputs_chk();
    // R6 R7 R8 sweep of the control byte
    for (int v = 0; v < 256; v++) begin
      reg_write('h51, 8'(v)); model['h51] = 8'(v);
      chk("R6", {6'b0, pf_dis[1:0]}, {6'b0, 2'(v >> 6)});
      chk("R7", {7'b0, sec_en}, {7'b0, 1'((v >> 3) & 1)});
      chk("R8", {7'b0, fast_host}, {7'b0, 1'((v & 'h27) == 'h27)});
    end
    // R6 R9 sweep of the shared drive 2/3 byte
    for (int v = 0; v < 256; v++) begin
      reg_write('h57, 8'(v)); model['h57] = 8'(v);
      chk("R6", {6'b0, pf_dis[3:2]}, {6'b0, 2'((v >> 2) & 3)});
      chk("R9", setup_tim[2], 8'(v));
    end
    // R10 index held across repeated data accesses
    io_write(base, 8'h5B);
    for (int k = 0; k < 4; k++) begin
      io_write(base + 10'd4, 8'(k * 51 + 3)); model['h5B] = 8'(k * 51 + 3);
      io_addr = base + 10'd4; #1; chk("R10", io_rdata, model['h5B]);
      io_addr = base; #1; chk("R10", io_rdata, 8'h5B);
    end
    // R2 alternate base decode
    @(negedge clk) alt_base = 1; model_ident();
    io_write(10'h17C, 8'hEE);             // old data port, now stray
    io_write(10'h178, 8'h52);             // old index port, now stray
    io_addr = 10'h07C; #1; chk("R2", io_rdata, model['h5B]);
    io_addr = 10'h17C; #1; chk("R2", io_rdata, 8'hFF);
    io_addr = 10'h078; #1; chk("R2", io_rdata, 8'h5B);
    for (int a = 0; a < 1024; a += 37) io_write(10'(a), 8'h99);
    io_write(10'h078, 8'h5B);
    io_addr = 10'h07C; #1; chk("R2", io_rdata, model['h5B]);
    reg_read_chk('h50, "R4");
    read_all();
    outputs_chk();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule